// File: doc/BRIEF.md
# Interrupt and Reset Response Sequencer

This block sits beside the instruction engine of an 8-bit processor with a 16-bit address space. At every instruction boundary it looks at three pending requests: reset, the non-maskable interrupt and the maskable interrupt. When it accepts one, it takes the processor over and runs a fixed, cycle-exact response. Each step of that response is one request to the bus cycle sequencer. A request carries a cycle kind, a nominal length in half-cycles, a flag saying whether the cycle has a WAIT sampling region, an address and write data. The bus cycle sequencer answers each request with a one-cycle `bus_done`, and a read also returns `bus_rdata`.

The response can push the program counter onto the stack, fetch a vector from a table, or hand a byte supplied on the bus to the decoder as the next opcode. At the end it emits load strobes with the new program counter and stack pointer, or an opcode-injection strobe, or a reset-apply strobe. Maskable interrupts have three modes, selected by a 2-bit mode input that is captured when the interrupt is accepted.

The state machine has these states:

- `ST_IDLE`: waits for a request. It goes to `ST_RST_WAIT`, `ST_NMI_FETCH` or `ST_ACK` when a request is granted.
- `ST_RST_WAIT`: goes to `ST_DONE`.
- `ST_NMI_FETCH`: goes to `ST_NMI_REFRESH`, which goes to `ST_PUSH_HI`.
- `ST_ACK`: goes to `ST_DONE` in mode 0, and to `ST_ACK_REFRESH` otherwise. `ST_ACK_REFRESH` goes to `ST_PUSH_HI`.
- `ST_PUSH_HI`: goes to `ST_PUSH_LO`.
- `ST_PUSH_LO`: goes to `ST_VEC_LO` for a mode 2 interrupt, and to `ST_DONE` otherwise.
- `ST_VEC_LO`: goes to `ST_VEC_HI`, which goes to `ST_DONE`.
- `ST_DONE`: goes back to `ST_IDLE`.

Every transition out of a bus state waits for `bus_done`.

Top module: `irs_seq`

## Requirements
- R1: A request is accepted only in a cycle where `at_boundary` is high and `busy` is low. The priority order is reset, then non-maskable interrupt, then maskable interrupt, and the maskable interrupt is accepted only when `irq_enabled` is high. Any other request is ignored, and neither `busy` nor `bus_req` rises.
- R2: The reset response issues a single request of kind 0 (internal), lasting 6 half-cycles, with no WAIT region. It then pulses `reset_apply` for one cycle. It never pulses `pc_load`.
- R3: The non-maskable response issues four requests in this order. First an opcode-fetch cycle (kind 1) of 4 half-cycles with a WAIT region, at the captured program counter. Then a refresh (kind 3) of 6 half-cycles. Then the two stack writes of R4. Finally it pulses `pc_load` with 0x0066.
- R4: A push writes the high program-counter byte at SP-1 and then the low byte at SP-2. Each write is kind 4, lasts 6 half-cycles and has a WAIT region. `sp_load` then carries SP-2, modulo 2^16.
- R5: Mode 0 (mode input 0) issues one acknowledge cycle (kind 2) of 8 half-cycles with a WAIT region. It then pulses `op_inject` and `refresh_hold` together with the acknowledged byte on `op_byte`. It does no stack write and no `pc_load`.
- R6: Mode 1 (mode input 1, and also mode input 3) issues an acknowledge cycle of 10 half-cycles with a WAIT region, then a refresh of 4 half-cycles, then the R4 push, then a `pc_load` of 0x0038. The nominal total is 26 half-cycles. The mode is captured at acceptance.
- R7: Mode 2 (mode input 2) runs the acknowledge, refresh and push of mode 1. It then makes two memory reads (kind 5) of 6 half-cycles with a WAIT region. The first read is at {`vec_page`, acknowledged byte} and the second at that pointer plus one, with the carry propagating into the high byte. `pc_load` then carries {second byte, first byte}.
- R8: In the acceptance cycle `en_clear` pulses for every accepted request. `en_save` pulses only when the accepted request is the non-maskable interrupt.
- R9: A pending bus request keeps its kind, length, WAIT flag, address and data stable until `bus_done`. Each `bus_done` advances exactly one step.
- R10: `busy` rises in the cycle after acceptance and stays high up to and including the cycle of the final strobe. It is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| at_boundary | input | 1 | Instruction boundary: requests may be taken |
| reset_req | input | 1 | Reset request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_enabled | input | 1 | Maskable interrupt enable state |
| irq_mode | input | 2 | Maskable interrupt mode |
| vec_page | input | 8 | High byte of the vector-table pointer |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | 16 | Current stack pointer |
| bus_req | output | 1 | Bus step requested |
| bus_kind | output | 3 | 0 internal, 1 opcode fetch, 2 acknowledge, 3 refresh, 4 write, 5 read |
| bus_half | output | 4 | Nominal length in half-cycles |
| bus_wait_en | output | 1 | Step has a WAIT sampling region |
| bus_addr | output | 16 | Step address (0 when the step has none) |
| bus_wdata | output | 8 | Write data (0 when the step is not a write) |
| bus_done | input | 1 | Current step completed |
| bus_rdata | input | 8 | Data returned by the step |
| busy | output | 1 | A response is in progress |
| en_clear | output | 1 | Clear the maskable enable state |
| en_save | output | 1 | Save the enable state for a later return |
| pc_load | output | 1 | Load the program counter |
| pc_next | output | 16 | New program counter |
| sp_load | output | 1 | Load the stack pointer |
| sp_next | output | 16 | New stack pointer |
| op_inject | output | 1 | Hand `op_byte` to decode as the next opcode |
| op_byte | output | 8 | Acknowledged byte |
| refresh_hold | output | 1 | Do not advance the refresh counter for this opcode |
| reset_apply | output | 1 | Apply the reset action |

## Verification
The assertions assume that the bus cycle sequencer raises `bus_done` only while `bus_req` is high, and for one cycle per step. They also assume that `rst_n` is held low from time zero until the first edges. The bench's bus model acknowledges only a request it has seen pending at a falling edge. It drops `bus_done` on the following falling edge, and it adds zero to three cycles of latency so that the fields must stay held through a wait. The request, mode, program-counter and stack-pointer inputs are changed only on falling edges. After acceptance they are scrambled, so that the bench can see the values captured at acceptance.

// File: rtl/irs_pkg.sv
package irs_pkg;

    typedef enum logic [2:0] {
        BK_INTERNAL = 3'd0,
        BK_OPFETCH  = 3'd1,
        BK_INTACK   = 3'd2,
        BK_REFRESH  = 3'd3,
        BK_MEMWR    = 3'd4,
        BK_MEMRD    = 3'd5
    } bus_kind_e;

    typedef enum logic [1:0] {
        GR_NONE  = 2'd0,
        GR_RESET = 2'd1,
        GR_NMI   = 2'd2,
        GR_IRQ   = 2'd3
    } grant_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_WAIT,
        ST_NMI_FETCH,
        ST_NMI_REFRESH,
        ST_ACK,
        ST_ACK_REFRESH,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_DONE
    } seq_state_e;

    localparam int HALF_W = 4;

    localparam logic [HALF_W-1:0] HC_RESET_INT   = 4'd6;
    localparam logic [HALF_W-1:0] HC_NMI_FETCH   = 4'd4;
    localparam logic [HALF_W-1:0] HC_NMI_REFRESH = 4'd6;
    localparam logic [HALF_W-1:0] HC_MEM         = 4'd6;
    localparam logic [HALF_W-1:0] HC_ACK_DIRECT  = 4'd8;
    localparam logic [HALF_W-1:0] HC_ACK_FULL    = 4'd10;
    localparam logic [HALF_W-1:0] HC_REFRESH     = 4'd4;

    localparam logic [1:0] MODE_DIRECT = 2'd0;
    localparam logic [1:0] MODE_TABLE  = 2'd2;

endpackage

// File: rtl/irs_arbiter.sv
module irs_arbiter
    import irs_pkg::*;
(
    input  logic   idle,
    input  logic   at_boundary,
    input  logic   reset_req,
    input  logic   nmi_req,
    input  logic   irq_req,
    input  logic   irq_enabled,
    output grant_e grant
);

    always_comb begin
        grant = GR_NONE;
        if (idle && at_boundary) begin
            if (reset_req) begin
                grant = GR_RESET;
            end else if (nmi_req) begin
                grant = GR_NMI;
            end else if (irq_req && irq_enabled) begin
                grant = GR_IRQ;
            end
        end
    end

endmodule

// File: rtl/irs_fsm.sv
module irs_fsm
    import irs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  grant_e            grant,
    input  logic [1:0]        irq_mode,
    input  logic              bus_done,
    output seq_state_e        state,
    output logic [1:0]        mode_q,
    output logic              bus_req,
    output logic [2:0]        bus_kind,
    output logic [HALF_W-1:0] bus_half,
    output logic              bus_wait_en,
    output logic              busy,
    output logic              en_clear,
    output logic              en_save,
    output logic              pc_load,
    output logic              sp_load,
    output logic              op_inject,
    output logic              refresh_hold,
    output logic              reset_apply
);

    seq_state_e state_d;
    grant_e     src_q;
    logic       direct_mode;
    logic       table_mode;

    assign direct_mode = (mode_q == MODE_DIRECT);
    assign table_mode  = (mode_q == MODE_TABLE);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                unique case (grant)
                    GR_RESET: state_d = ST_RST_WAIT;
                    GR_NMI:   state_d = ST_NMI_FETCH;
                    GR_IRQ:   state_d = ST_ACK;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_RST_WAIT:    if (bus_done) state_d = ST_DONE;
            ST_NMI_FETCH:   if (bus_done) state_d = ST_NMI_REFRESH;
            ST_NMI_REFRESH: if (bus_done) state_d = ST_PUSH_HI;
            ST_ACK:         if (bus_done) state_d = direct_mode ? ST_DONE : ST_ACK_REFRESH;
            ST_ACK_REFRESH: if (bus_done) state_d = ST_PUSH_HI;
            ST_PUSH_HI:     if (bus_done) state_d = ST_PUSH_LO;
            ST_PUSH_LO: begin
                if (bus_done) begin
                    state_d = (src_q == GR_IRQ && table_mode) ? ST_VEC_LO : ST_DONE;
                end
            end
            ST_VEC_LO:      if (bus_done) state_d = ST_VEC_HI;
            ST_VEC_HI:      if (bus_done) state_d = ST_DONE;
            ST_DONE:        state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            src_q  <= GR_NONE;
            mode_q <= 2'd0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && grant != GR_NONE) begin
                src_q <= grant;
                if (grant == GR_IRQ) begin
                    mode_q <= irq_mode;
                end
            end
        end
    end

    always_comb begin
        bus_req      = 1'b0;
        bus_kind     = BK_INTERNAL;
        bus_half     = '0;
        bus_wait_en  = 1'b0;
        busy         = 1'b1;
        en_clear     = 1'b0;
        en_save      = 1'b0;
        pc_load      = 1'b0;
        sp_load      = 1'b0;
        op_inject    = 1'b0;
        refresh_hold = 1'b0;
        reset_apply  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                en_clear = (grant != GR_NONE);
                en_save  = (grant == GR_NMI);
            end
            ST_RST_WAIT: begin
                bus_req  = 1'b1;
                bus_kind = BK_INTERNAL;
                bus_half = HC_RESET_INT;
            end
            ST_NMI_FETCH: begin
                bus_req     = 1'b1;
                bus_kind    = BK_OPFETCH;
                bus_half    = HC_NMI_FETCH;
                bus_wait_en = 1'b1;
            end
            ST_NMI_REFRESH: begin
                bus_req  = 1'b1;
                bus_kind = BK_REFRESH;
                bus_half = HC_NMI_REFRESH;
            end
            ST_ACK: begin
                bus_req     = 1'b1;
                bus_kind    = BK_INTACK;
                bus_half    = direct_mode ? HC_ACK_DIRECT : HC_ACK_FULL;
                bus_wait_en = 1'b1;
            end
            ST_ACK_REFRESH: begin
                bus_req  = 1'b1;
                bus_kind = BK_REFRESH;
                bus_half = HC_REFRESH;
            end
            ST_PUSH_HI, ST_PUSH_LO: begin
                bus_req     = 1'b1;
                bus_kind    = BK_MEMWR;
                bus_half    = HC_MEM;
                bus_wait_en = 1'b1;
            end
            ST_VEC_LO, ST_VEC_HI: begin
                bus_req     = 1'b1;
                bus_kind    = BK_MEMRD;
                bus_half    = HC_MEM;
                bus_wait_en = 1'b1;
            end
            ST_DONE: begin
                unique case (src_q)
                    GR_RESET: reset_apply = 1'b1;
                    GR_IRQ: begin
                        if (direct_mode) begin
                            op_inject    = 1'b1;
                            refresh_hold = 1'b1;
                        end else begin
                            pc_load = 1'b1;
                            sp_load = 1'b1;
                        end
                    end
                    default: begin
                        pc_load = 1'b1;
                        sp_load = 1'b1;
                    end
                endcase
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/irs_datapath.sv
module irs_datapath
    import irs_pkg::*;
#(
    parameter int                  ADDR_W     = 16,
    parameter int                  DATA_W     = 8,
    parameter logic [ADDR_W-1:0]   NMI_TARGET = 16'h0066,
    parameter logic [ADDR_W-1:0]   RST_TARGET = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  grant_e            grant,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] vec_page,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] sp_cur,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] sp_next,
    output logic [DATA_W-1:0] op_byte
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [DATA_W-1:0] ack_q;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] sp_dec;

    assign ptr    = {vec_page, ack_q};
    assign sp_dec = sp_q - ADDR_ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            tgt_q <= '0;
            ack_q <= '0;
        end else if (state == ST_IDLE) begin
            if (grant != GR_NONE) begin
                pc_q  <= pc_cur;
                sp_q  <= sp_cur;
                tgt_q <= (grant == GR_NMI) ? NMI_TARGET : RST_TARGET;
            end
        end else if (bus_done) begin
            unique case (state)
                ST_ACK:                 ack_q <= bus_rdata;
                ST_PUSH_HI, ST_PUSH_LO: sp_q <= sp_dec;
                ST_VEC_LO:              tgt_q[DATA_W-1:0] <= bus_rdata;
                ST_VEC_HI:              tgt_q[ADDR_W-1:DATA_W] <= bus_rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_NMI_FETCH: bus_addr = pc_q;
            ST_PUSH_HI: begin
                bus_addr  = sp_dec;
                bus_wdata = pc_q[ADDR_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                bus_addr  = sp_dec;
                bus_wdata = pc_q[DATA_W-1:0];
            end
            ST_VEC_LO: bus_addr = ptr;
            ST_VEC_HI: bus_addr = ptr + ADDR_ONE;
            default: ;
        endcase
    end

    assign pc_next = tgt_q;
    assign sp_next = sp_q;
    assign op_byte = ack_q;

endmodule

// File: rtl/irs_seq.sv
module irs_seq
    import irs_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] NMI_TARGET = 16'h0066,
    parameter logic [ADDR_W-1:0] RST_TARGET = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  logic              reset_req,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              irq_enabled,
    input  logic [1:0]        irq_mode,
    input  logic [DATA_W-1:0] vec_page,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] sp_cur,
    output logic              bus_req,
    output logic [2:0]        bus_kind,
    output logic [HALF_W-1:0] bus_half,
    output logic              bus_wait_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              en_clear,
    output logic              en_save,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_next,
    output logic              sp_load,
    output logic [ADDR_W-1:0] sp_next,
    output logic              op_inject,
    output logic [DATA_W-1:0] op_byte,
    output logic              refresh_hold,
    output logic              reset_apply
);

    seq_state_e state;
    grant_e     grant;
    logic [1:0] mode_q;

    irs_arbiter u_arb (
        .idle        (state == ST_IDLE),
        .at_boundary (at_boundary),
        .reset_req   (reset_req),
        .nmi_req     (nmi_req),
        .irq_req     (irq_req),
        .irq_enabled (irq_enabled),
        .grant       (grant)
    );

    irs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .irq_mode     (irq_mode),
        .bus_done     (bus_done),
        .state        (state),
        .mode_q       (mode_q),
        .bus_req      (bus_req),
        .bus_kind     (bus_kind),
        .bus_half     (bus_half),
        .bus_wait_en  (bus_wait_en),
        .busy         (busy),
        .en_clear     (en_clear),
        .en_save      (en_save),
        .pc_load      (pc_load),
        .sp_load      (sp_load),
        .op_inject    (op_inject),
        .refresh_hold (refresh_hold),
        .reset_apply  (reset_apply)
    );

    irs_datapath #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NMI_TARGET (NMI_TARGET),
        .RST_TARGET (RST_TARGET)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .grant     (grant),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .vec_page  (vec_page),
        .pc_cur    (pc_cur),
        .sp_cur    (sp_cur),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pc_next   (pc_next),
        .sp_next   (sp_next),
        .op_byte   (op_byte)
    );

endmodule

// File: rtl/irs_seq_chk.sv
module irs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic [2:0]  bus_kind,
    input logic [3:0]  bus_half,
    input logic        bus_wait_en,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_done,
    input logic        busy,
    input logic        en_clear,
    input logic        en_save,
    input logic        pc_load,
    input logic        sp_load,
    input logic        op_inject,
    input logic        reset_apply
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_direct_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_inject |-> (!pc_load && !sp_load && !bus_req));

    assert_reset_no_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_apply |-> (!pc_load && !sp_load));

    assert_save_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_save |-> (en_clear && !busy));

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_kind) && $stable(bus_half)
                                    && $stable(bus_wait_en) && $stable(bus_addr)
                                    && $stable(bus_wdata)));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_clear |=> busy);

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || op_inject || reset_apply) |=> !busy);

    assert_single_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_load, op_inject, reset_apply}));

endmodule

bind irs_seq irs_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_kind    (bus_kind),
    .bus_half    (bus_half),
    .bus_wait_en (bus_wait_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_done    (bus_done),
    .busy        (busy),
    .en_clear    (en_clear),
    .en_save     (en_save),
    .pc_load     (pc_load),
    .sp_load     (sp_load),
    .op_inject   (op_inject),
    .reset_apply (reset_apply)
);

// File: tb/irs_seq_tb.sv
module irs_seq_tb;

    typedef struct packed {
        logic        bnd;
        logic        rst;
        logic        nmi;
        logic        irq;
        logic        ie;
        logic [1:0]  mode;
        logic [1:0]  lat;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  ivec;
        logic [7:0]  ack;
        logic [7:0]  lo;
        logic [7:0]  hi;
    } case_t;

    localparam int NCASE = 12;
    localparam case_t CASES [NCASE] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 16'h1111, 16'h2222, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 16'h1234, 16'h8000, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 16'hABCD, 16'h0001, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1, 16'h2468, 16'h9000, 8'h00, 8'hC7, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, 16'h4000, 16'hC000, 8'h00, 8'h5A, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 2'd1, 16'h0102, 16'h0203, 8'h00, 8'h11, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 16'h7777, 16'hF000, 8'h12, 8'hFF, 8'h34, 8'h56},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd3, 16'h0FF0, 16'h0100, 8'h80, 8'h40, 8'h00, 8'h90},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 16'h3333, 16'h4444, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 16'h5555, 16'h6666, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 16'h8888, 16'h9999, 8'h00, 8'h00, 8'h00, 8'h00},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 16'hCAFE, 16'hBEEF, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        at_boundary = 1'b0;
    logic        reset_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_enabled = 1'b0;
    logic [1:0]  irq_mode = 2'd0;
    logic [7:0]  vec_page = 8'h00;
    logic [15:0] pc_cur = 16'h0000;
    logic [15:0] sp_cur = 16'h0000;
    logic        bus_done = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_req;
    logic [2:0]  bus_kind;
    logic [3:0]  bus_half;
    logic        bus_wait_en;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        busy;
    logic        en_clear;
    logic        en_save;
    logic        pc_load;
    logic [15:0] pc_next;
    logic        sp_load;
    logic [15:0] sp_next;
    logic        op_inject;
    logic [7:0]  op_byte;
    logic        refresh_hold;
    logic        reset_apply;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irs_seq u_dut (
        .clk (clk), .rst_n (rst_n), .at_boundary (at_boundary),
        .reset_req (reset_req), .nmi_req (nmi_req), .irq_req (irq_req),
        .irq_enabled (irq_enabled), .irq_mode (irq_mode), .vec_page (vec_page),
        .pc_cur (pc_cur), .sp_cur (sp_cur), .bus_req (bus_req), .bus_kind (bus_kind),
        .bus_half (bus_half), .bus_wait_en (bus_wait_en), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_done (bus_done), .bus_rdata (bus_rdata),
        .busy (busy), .en_clear (en_clear), .en_save (en_save), .pc_load (pc_load),
        .pc_next (pc_next), .sp_load (sp_load), .sp_next (sp_next),
        .op_inject (op_inject), .op_byte (op_byte), .refresh_hold (refresh_hold),
        .reset_apply (reset_apply)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [31:0] step(input logic [2:0] k, input logic [3:0] h,
                                         input logic w, input logic [15:0] a,
                                         input logic [7:0] d);
        return {k, h, w, a, d};
    endfunction

    task automatic clear_reqs();
        at_boundary = 1'b0;
        reset_req   = 1'b0;
        nmi_req     = 1'b0;
        irq_req     = 1'b0;
    endtask

    task automatic run_case(input case_t c, input bit hold, input string name);
        int which;
        int nexp;
        int nrec;
        int wc;
        int rdn;
        int pcl;
        int spl;
        int opi;
        int rha;
        int rfh;
        logic [31:0] expv [8];
        logic [31:0] rec [8];
        logic [15:0] pcv;
        logic [15:0] spv;
        logic [15:0] exp_pc;
        logic [15:0] ptr;
        logic [7:0]  opv;
        logic        m1;
        nexp = 0; nrec = 0; wc = 0; rdn = 0;
        pcl = 0; spl = 0; opi = 0; rha = 0; rfh = 0;
        pcv = '0; spv = '0; opv = '0; exp_pc = '0;
        for (int i = 0; i < 8; i++) begin
            expv[i] = '0;
            rec[i]  = '0;
        end
        ptr = {c.ivec, c.ack};
        m1  = (c.mode == 2'd1) || (c.mode == 2'd3);
        if (!c.bnd) which = 3;
        else if (c.rst) which = 0;
        else if (c.nmi) which = 1;
        else if (c.irq && c.ie) which = 2;
        else which = 3;

        if (which == 0) begin
            expv[0] = step(3'd0, 4'd6, 1'b0, 16'h0000, 8'h00);
            nexp = 1;
        end else if (which == 1) begin
            expv[0] = step(3'd1, 4'd4, 1'b1, c.pc, 8'h00);
            expv[1] = step(3'd3, 4'd6, 1'b0, 16'h0000, 8'h00);
            nexp = 2;
            exp_pc = 16'h0066;
        end else if (which == 2) begin
            expv[0] = step(3'd2, (c.mode == 2'd0) ? 4'd8 : 4'd10, 1'b1, 16'h0000, 8'h00);
            nexp = 1;
            if (c.mode != 2'd0) begin
                expv[1] = step(3'd3, 4'd4, 1'b0, 16'h0000, 8'h00);
                nexp = 2;
            end
            exp_pc = m1 ? 16'h0038 : {c.hi, c.lo};
        end
        if (which == 1 || (which == 2 && c.mode != 2'd0)) begin
            expv[nexp]   = step(3'd4, 4'd6, 1'b1, c.sp - 16'd1, c.pc[15:8]);
            expv[nexp+1] = step(3'd4, 4'd6, 1'b1, c.sp - 16'd2, c.pc[7:0]);
            nexp += 2;
        end
        if (which == 2 && c.mode == 2'd2) begin
            expv[nexp]   = step(3'd5, 4'd6, 1'b1, ptr, 8'h00);
            expv[nexp+1] = step(3'd5, 4'd6, 1'b1, ptr + 16'd1, 8'h00);
            nexp += 2;
        end

        @(negedge clk);
        at_boundary = c.bnd; reset_req = c.rst; nmi_req = c.nmi; irq_req = c.irq;
        irq_enabled = c.ie; irq_mode = c.mode; vec_page = c.ivec;
        pc_cur = c.pc; sp_cur = c.sp;
        #1;
        chk({name, " R8 en_clear at acceptance"}, 32'(en_clear), 32'(which != 3));
        chk({name, " R8 en_save only for NMI"}, 32'(en_save), 32'(which == 1));

        for (int cyc = 0; cyc < 300; cyc++) begin
            @(negedge clk);
            if (cyc == 0) begin
                if (!hold) clear_reqs();
                irq_mode = ~c.mode;
                pc_cur   = ~c.pc;
                sp_cur   = ~c.sp;
                chk({name, " R10/R1 busy after acceptance"}, 32'(busy), 32'(which != 3));
            end
            if (!busy) break;
            if (pc_load) begin
                pcl++; pcv = pc_next;
                if (hold) clear_reqs();
            end
            if (sp_load) begin spl++; spv = sp_next; end
            if (op_inject) begin opi++; opv = op_byte; end
            if (refresh_hold) rfh++;
            if (reset_apply) rha++;
            if (bus_done) begin
                bus_done = 1'b0;
            end else if (bus_req) begin
                if (wc == int'(c.lat)) begin
                    if (nrec < 8) rec[nrec] = step(bus_kind, bus_half, bus_wait_en, bus_addr, bus_wdata);
                    nrec++;
                    if (bus_kind == 3'd2) bus_rdata = c.ack;
                    else if (bus_kind == 3'd5) begin
                        bus_rdata = (rdn == 0) ? c.lo : c.hi;
                        rdn++;
                    end else bus_rdata = 8'hFF;
                    bus_done = 1'b1;
                    wc = 0;
                end else begin
                    wc++;
                end
            end
        end
        chk({name, " R9 one step per done (step count)"}, 32'(nrec), 32'(nexp));
        for (int i = 0; i < nexp && i < 8; i++) begin
            chk($sformatf("%s R3/R4/R5/R6/R7 step %0d", name, i), rec[i], expv[i]);
        end
        chk({name, " R2 reset_apply count"}, 32'(rha), 32'(which == 0));
        chk({name, " R5 op_inject count"}, 32'(opi), 32'(which == 2 && c.mode == 2'd0));
        chk({name, " R5 refresh_hold count"}, 32'(rfh), 32'(which == 2 && c.mode == 2'd0));
        if (which == 2 && c.mode == 2'd0) begin
            chk({name, " R5 injected opcode byte"}, 32'(opv), 32'(c.ack));
        end
        if (which == 1 || (which == 2 && c.mode != 2'd0)) begin
            chk({name, " R3 pc_load count"}, 32'(pcl), 32'd1);
            chk({name, " R6/R7 new program counter"}, 32'(pcv), 32'(exp_pc));
            chk({name, " R4 new stack pointer"}, 32'(spv), 32'(16'(c.sp - 16'd2)));
        end else begin
            chk({name, " R2/R5 no pc_load"}, 32'(pcl), 32'd0);
        end
        bus_done = 1'b0;
        clear_reqs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, run hung");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset state busy", 32'(busy), 32'd0);
        chk("R1 reset state bus_req", 32'(bus_req), 32'd0);
        chk("R10 reset state strobes", 32'({pc_load, sp_load, op_inject, reset_apply, en_clear}), 32'd0);

        for (int k = 0; k < NCASE; k++) begin
            run_case(CASES[k], 1'b0, $sformatf("case%0d", k));
        end

        run_case('{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 16'h2020, 16'h3030,
                   8'h00, 8'h00, 8'h00, 8'h00}, 1'b1, "R1 busy_ignores_requests");
        repeat (2) @(negedge clk);
        chk("R1 no re-entry after held requests", 32'(busy), 32'd0);

        summary();
    end

endmodule